// File: doc/BRIEF.md
# Register Access SPI Slave

This block sits between an external SPI host and the register file of a transceiver core. The host pulls the active-low select low, clocks in a header byte and then two or more payload bytes, and releases the select. The header gives a 6-bit register address and the direction. Payload bytes are grouped into 16-bit words, high byte first. On a write, each finished word becomes one write strobe toward the core. On a read, the core is asked for a word and the block shifts that word out on MISO. Data moves one way only in any transaction.

The SPI pins are asynchronous to the system clock. They are brought through synchronizer stages and their edges are detected in the system clock domain. The system clock must therefore run several times faster than SCK; SCK is at most 8 MHz. The SPI mode is clock idle low: data is sampled on the rising edge and MISO changes on the falling edge. A multi-word payload steps through consecutive addresses. The core sees a simple synchronous register port: address, write data, a write strobe, a read strobe, and read data that it returns in the same cycle as the read strobe.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, `reg_wr`, `reg_rd`, `spi_miso_oe` and `spi_miso` are all 0.
- R2: The first byte of each transaction is the header. Bit 7 = 1 selects a read and 0 selects a write. Bits 5:0 are the starting address. Bit 6 is ignored.
- R3: Bytes on MOSI are taken most significant bit first, each bit sampled on the rising SCK edge.
- R4: Write payload bytes pair into 16-bit words, high byte first. Each complete word gives exactly one single-cycle `reg_wr` pulse, with `reg_addr` and `reg_wdata` valid in that cycle.
- R5: Each word after the first in a transaction uses the next address. The 6-bit address wraps from 63 to 0.
- R6: In a read, `reg_rd` pulses with the word's address and `reg_rdata` is taken in that cycle. The word is returned on MISO high byte first, MSB first, with changes on falling SCK edges. It is valid at each rising edge of the payload bursts.
- R7: During a read, MOSI payload content is ignored and no `reg_wr` is produced.
- R8: `spi_miso_oe` is 0 while the select is high and 1 while it is low.
- R9: A transaction that ends before its second payload byte completes writes nothing. Trailing bytes or bits that do not complete a word are dropped.
- R10: Each falling select edge restarts at the header, whatever partial bits the previous transaction left behind.
- R11: During a write transaction, MISO is driven 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times the SCK rate |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI clock from the host, idles low |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for MISO (0 = high impedance) |
| reg_addr | output | 6 | Register address toward the core |
| reg_wdata | output | 16 | Write data toward the core |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 16 | Read data from the core, valid in the `reg_rd` cycle |

## Verification
A corrupted bit counter or header decode shows up at once as a write to the wrong address or with rotated data. The scoreboard catches it on the very strobe that carries it. A stale word index or hold byte swaps halves of `reg_wdata` on the first word, and a wrong address step shows on the second word of a burst. On the read side, a late or wrong prefetch shows as a wrong MISO bit at the first rising SCK edge of the payload. Leftover state from an aborted transaction appears as an unexpected strobe or a misaligned word in the next transaction.

// File: rtl/spi_reg_pkg.sv
// Package: shared types and constants for the SPI register access port.
// Assumes: one header byte, byte-wide SPI bursts, words a whole number of bytes.
package spi_reg_pkg;
    // Transaction phase: header byte first, then payload bytes.
    typedef enum logic {
        PH_HEADER = 1'b0,
        PH_DATA   = 1'b1
    } phase_e;

    // Header bit that selects a read when set.
    localparam int HDR_RD_BIT = 7;
endpackage

// File: rtl/spi_pin_sync.sv
// Module: spi_pin_sync
// Brings the asynchronous SPI pins into the system clock domain and detects
// SCK and select edges there.
// Assumes: clk runs several times faster than SCK; STAGES >= 2.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_pin,
    input  logic cs_n_pin,
    input  logic mosi_pin,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_active,
    output logic cs_start,
    output logic mosi_s
);
    logic [STAGES-1:0] sck_chain;
    logic [STAGES-1:0] cs_chain;
    logic [STAGES-1:0] mosi_chain;
    logic              sck_last;
    logic              cs_last;
    logic              sck_s;
    logic              cs_s;

    // Purpose: shift each pin through its synchronizer chain (first stage).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_chain[0]  <= 1'b0;
            cs_chain[0]   <= 1'b1;
            mosi_chain[0] <= 1'b0;
        end else begin
            sck_chain[0]  <= sck_pin;
            cs_chain[0]   <= cs_n_pin;
            mosi_chain[0] <= mosi_pin;
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Purpose: later synchronizer stages, one per extra stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sck_chain[g]  <= 1'b0;
                cs_chain[g]   <= 1'b1;
                mosi_chain[g] <= 1'b0;
            end else begin
                sck_chain[g]  <= sck_chain[g-1];
                cs_chain[g]   <= cs_chain[g-1];
                mosi_chain[g] <= mosi_chain[g-1];
            end
        end
    end

    assign sck_s  = sck_chain[STAGES-1];
    assign cs_s   = cs_chain[STAGES-1];
    assign mosi_s = mosi_chain[STAGES-1];

    // Purpose: hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_last <= 1'b0;
            cs_last  <= 1'b1;
        end else begin
            sck_last <= sck_s;
            cs_last  <= cs_s;
        end
    end

    assign sck_rise  = sck_s & ~sck_last;
    assign sck_fall  = ~sck_s & sck_last;
    assign cs_active = ~cs_s;
    assign cs_start  = ~cs_s & cs_last;
endmodule

// File: rtl/spi_byte_shifter.sv
// Module: spi_byte_shifter
// Assembles MOSI bits into bytes on rising SCK and drives MISO bits on
// falling SCK, MSB first. Counts bits within the current burst.
// Assumes: edge pulses come from spi_pin_sync; tx_byte is stable before the
// falling edge that starts each byte.
module spi_byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_active,
    input  logic              cs_start,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_done,
    output logic              miso_q,
    output logic              miso_oe
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;

    // Purpose: receive shift register, bit counter and byte-complete pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt    <= '0;
            shreg     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!cs_active || cs_start) begin
                bitcnt <= '0;
            end else if (sck_rise) begin
                shreg <= {shreg[BYTE_W-2:0], mosi_s};
                if (bitcnt == LAST_BIT) begin
                    bitcnt    <= '0;
                    byte_done <= 1'b1;
                    rx_byte   <= {shreg[BYTE_W-2:0], mosi_s};
                end else begin
                    bitcnt <= bitcnt + CNT_W'(1);
                end
            end
        end
    end

    // Purpose: MISO data on falling SCK and output enable from the select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miso_q  <= 1'b0;
            miso_oe <= 1'b0;
        end else begin
            miso_oe <= cs_active;
            if (!cs_active || cs_start) begin
                miso_q <= 1'b0;
            end else if (sck_fall) begin
                miso_q <= tx_byte[LAST_BIT - bitcnt];
            end
        end
    end

    // R8: entering a transaction turns the MISO driver on.
    a_r8_oe_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        cs_start |=> miso_oe);
    // R10: a fresh select cannot deliver a byte on the next cycle.
    a_r10_no_instant_byte: assert property (@(posedge clk) disable iff (!rst_n)
        cs_start |=> !byte_done);
endmodule

// File: rtl/spi_txn_ctrl.sv
// Module: spi_txn_ctrl
// Decodes the header, groups payload bytes into words, issues register
// strobes and steps the address; supplies the next MISO byte on reads.
// Assumes: DATA_W is at least two bytes; the core returns reg_rdata in the
// same cycle as reg_rd.
module spi_txn_ctrl
    import spi_reg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd
);
    localparam int WORD_BYTES = DATA_W / BYTE_W;
    localparam int IDX_W      = (WORD_BYTES > 2) ? $clog2(WORD_BYTES) : 1;
    localparam int HOLD_W     = DATA_W - BYTE_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

    phase_e            phase;
    logic              is_read;
    logic [IDX_W-1:0]  idx;
    logic [HOLD_W-1:0] hold;
    logic [DATA_W-1:0] rd_shift;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wr_q;
    logic              rd_q;
    logic              last_byte;

    assign last_byte = (idx == LAST_IDX);

    // Purpose: transaction sequencing, word assembly, strobes and address steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_HEADER;
            is_read  <= 1'b0;
            idx      <= '0;
            hold     <= '0;
            rd_shift <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
        end else begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
            if (wr_q) begin
                addr_q <= addr_q + ADDR_W'(1);
            end
            if (rd_q) begin
                rd_shift <= reg_rdata;
            end
            if (!cs_active) begin
                phase   <= PH_HEADER;
                is_read <= 1'b0;
                idx     <= '0;
            end else if (byte_done) begin
                if (phase == PH_HEADER) begin
                    phase   <= PH_DATA;
                    is_read <= rx_byte[HDR_RD_BIT];
                    addr_q  <= rx_byte[ADDR_W-1:0];
                    idx     <= '0;
                    rd_q    <= rx_byte[HDR_RD_BIT];
                end else begin
                    idx <= last_byte ? '0 : idx + IDX_W'(1);
                    if (is_read) begin
                        rd_shift <= rd_shift << BYTE_W;
                        if (last_byte) begin
                            addr_q <= addr_q + ADDR_W'(1);
                            rd_q   <= 1'b1;
                        end
                    end else if (last_byte) begin
                        wr_q    <= 1'b1;
                        wdata_q <= {hold, rx_byte};
                    end else begin
                        hold <= HOLD_W'({hold, rx_byte});
                    end
                end
            end
        end
    end

    assign tx_byte   = is_read ? rd_shift[DATA_W-1 -: BYTE_W] : '0;
    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;
    assign reg_wr    = wr_q;
    assign reg_rd    = rd_q;

    // R4: a write strobe lasts one cycle.
    a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    // R5: the address steps by one after each written word.
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_addr == $past(reg_addr) + ADDR_W'(1)));
    // R7: reads and writes never strobe together.
    a_r7_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
    // R2: the direction stays fixed for the whole payload.
    a_r2_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && $past(phase) == PH_DATA) |-> $stable(is_read));
endmodule

// File: rtl/spi_reg_port.sv
// Module: spi_reg_port (top)
// SPI slave register access port: header plus one-way payload transactions
// mapped onto a synchronous register port.
// Assumes: clk at least several times the SCK rate; core read data combinational.
module spi_reg_port #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int BYTE_W = 8;

    logic              sck_rise;
    logic              sck_fall;
    logic              cs_active;
    logic              cs_start;
    logic              mosi_s;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] tx_byte;
    logic              byte_done;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_pin  (spi_sck),
        .cs_n_pin (spi_cs_n),
        .mosi_pin (spi_mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_active(cs_active),
        .cs_start (cs_start),
        .mosi_s   (mosi_s)
    );

    spi_byte_shifter #(.BYTE_W(BYTE_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_active(cs_active),
        .cs_start (cs_start),
        .mosi_s   (mosi_s),
        .tx_byte  (tx_byte),
        .rx_byte  (rx_byte),
        .byte_done(byte_done),
        .miso_q   (spi_miso),
        .miso_oe  (spi_miso_oe)
    );

    spi_txn_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_active(cs_active),
        .byte_done(byte_done),
        .rx_byte  (rx_byte),
        .reg_rdata(reg_rdata),
        .tx_byte  (tx_byte),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd)
    );

    // R6: a read strobe only occurs while the port drives MISO.
    a_r6_rd_selected: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> spi_miso_oe);
endmodule

// File: tb/test_spi_reg_port.sv
// Bench: scoreboard. Driver tasks push the expected strobes into queues; a
// monitor pops and compares them as the design issues them.
module test_spi_reg_port;
    localparam int HALF = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        spi_miso_oe;
    logic [5:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_wr;
    logic        reg_rd;
    logic [15:0] reg_rdata;

    logic [15:0] regs [64];
    logic [21:0] wq [$];
    logic [5:0]  rq [$];
    logic [15:0] buf_w [8];
    int checks = 0;
    int errors = 0;
    int wr_seen = 0;
    int wr_expect = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    assign reg_rdata = regs[reg_addr];

    spi_reg_port i_spi_reg_port (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    // Monitor: compares strobes with the scoreboard and updates the model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                wr_seen++;
                if (wq.size() == 0) chk("R9 unexpected write", {10'd0, reg_addr, reg_wdata}, 32'hFFFFFFFF);
                else chk("R3/R4/R5 write strobe", {10'd0, reg_addr, reg_wdata}, {10'd0, wq.pop_front()});
                regs[reg_addr] = reg_wdata;
            end
            if (reg_rd) begin
                if (rq.size() == 0) chk("R6 unexpected read", {26'd0, reg_addr}, 32'hFFFFFFFF);
                else chk("R6 read strobe address", {26'd0, reg_addr}, {26'd0, rq.pop_front()});
            end
        end
    end

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b1;
            rx[i] = spi_miso;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic sel_low();
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic sel_high();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    // Write n words from buf_w starting at addr; header bit 6 set by b6.
    task automatic do_write(input logic [5:0] addr, input logic b6, input int n);
        logic [7:0] rx;
        logic [7:0] rx_or = '0;
        for (int i = 0; i < n; i++) wq.push_back({6'(addr + 6'(i)), buf_w[i]});
        wr_expect += n;
        sel_low();
        spi_bits({1'b0, b6, addr}, 8, rx);
        for (int i = 0; i < n; i++) begin
            spi_bits(buf_w[i][15:8], 8, rx); rx_or |= rx;
            spi_bits(buf_w[i][7:0], 8, rx);  rx_or |= rx;
        end
        chk("R11 MISO low during write", {24'd0, rx_or}, 32'd0);
        chk("R8 MISO driven while selected", {31'd0, spi_miso_oe}, 32'd1);
        sel_high();
        chk("R8 MISO released after deselect", {31'd0, spi_miso_oe}, 32'd0);
        chk("R4 write count", wr_seen, wr_expect);
    endtask

    // Read n words from addr while driving junk on MOSI.
    task automatic do_read(input logic [5:0] addr, input int n, input logic [7:0] junk);
        logic [7:0] hi;
        logic [7:0] lo;
        logic [15:0] exp [8];
        for (int i = 0; i < n; i++) exp[i] = regs[6'(addr + 6'(i))];
        for (int i = 0; i <= n; i++) rq.push_back(6'(addr + 6'(i)));
        sel_low();
        spi_bits({2'b10, addr}, 8, hi);
        for (int i = 0; i < n; i++) begin
            spi_bits(junk, 8, hi);
            spi_bits(~junk, 8, lo);
            chk("R6/R7 read word on MISO", {16'd0, hi, lo}, {16'd0, exp[i]});
        end
        sel_high();
        chk("R7 no write during read", wr_seen, wr_expect);
    endtask

    initial begin
        logic [7:0] rx;
        repeat (4) @(negedge clk);
        chk("R1 reset reg_wr", {31'd0, reg_wr}, 32'd0);
        chk("R1 reset reg_rd", {31'd0, reg_rd}, 32'd0);
        chk("R1 reset miso_oe", {31'd0, spi_miso_oe}, 32'd0);
        chk("R1 reset miso", {31'd0, spi_miso}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 R3 R4: single word write
        buf_w[0] = 16'hA53C;
        do_write(6'd5, 1'b0, 1);
        // R5: three words auto-increment
        buf_w[0] = 16'h1234; buf_w[1] = 16'h8001; buf_w[2] = 16'hFEDC;
        do_write(6'd10, 1'b0, 3);
        // R2: header bit 6 ignored
        buf_w[0] = 16'h0F0F;
        do_write(6'd20, 1'b1, 1);
        // R5: wrap from 63 to 0
        buf_w[0] = 16'h6363; buf_w[1] = 16'h0000 ^ 16'h5AA5;
        do_write(6'd63, 1'b0, 2);

        // R6 R7: reads with different MOSI junk
        do_read(6'd5, 1, 8'hFF);
        do_read(6'd10, 3, 8'hA5);
        do_read(6'd63, 2, 8'h00);

        // R9: abort after one payload byte
        sel_low();
        spi_bits(8'h05, 8, rx);
        spi_bits(8'h99, 8, rx);
        sel_high();
        chk("R9 no write on short abort", wr_seen, wr_expect);
        // R9: abort inside the second payload byte
        sel_low();
        spi_bits(8'h05, 8, rx);
        spi_bits(8'h77, 8, rx);
        spi_bits(8'h66, 5, rx);
        sel_high();
        chk("R9 no write on partial word", wr_seen, wr_expect);
        do_read(6'd5, 1, 8'h3C);

        // R9: one full word then a trailing partial byte
        wq.push_back({6'd30, 16'hBEEF});
        wr_expect += 1;
        sel_low();
        spi_bits(8'h1E, 8, rx);
        spi_bits(8'hBE, 8, rx);
        spi_bits(8'hEF, 8, rx);
        spi_bits(8'hCA, 8, rx);
        spi_bits(8'hFE, 3, rx);
        sel_high();
        chk("R9 only complete words written", wr_seen, wr_expect);
        do_read(6'd31, 1, 8'h00);

        // R10: leftover bits from an aborted header do not shift the next one
        sel_low();
        spi_bits(8'hFF, 5, rx);
        sel_high();
        buf_w[0] = 16'hC001;
        do_write(6'd7, 1'b0, 1);
        do_read(6'd7, 1, 8'h81);

        chk("R4 scoreboard drained", wq.size() + rq.size(), 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule